// File: doc/BRIEF.md
# Overlapped Register Window File

This block is the general-purpose register file of a RISC-style CPU whose procedures each see 32 logical registers. Those registers are placed onto a smaller physical array through a circular window pointer. Ten registers are global and are visible from every window. The remaining 22 logical registers of a window form three regions. The region a caller fills with outgoing parameters is the same physical storage as the region its callee reads as incoming parameters, so a procedure call passes arguments without copying them.

There are two combinational read ports and one write port that is applied at the clock edge. All three are addressed by a 5-bit logical register number and are translated through the window that is current in that cycle. A call strobe moves the window forward and a return strobe moves it back. A count of resident windows flags the cycles in which an outer spill or refill would be needed. The block only reports these events and does not move any data to memory.

Top module: `wrf`

## Requirements
- R1: While `rst` is high at a rising edge, the window index is set to 0, both flags are cleared and the resident-window count is set to 1.
- R2: Logical registers 0–9 are global. A value written to one of them in any window reads back unchanged from the same logical number in every other window.
- R3: Logical registers 16–25 are private to each window. A write to one of them in window w does not change what window w reads there after a call and the matching return.
- R4: Logical registers 26–31 of window w are the same storage as logical registers 10–15 of window w+1. Logical register 26+k corresponds to 10+k.
- R5: The windows form a ring of 4. Logical registers 26–31 of window 3 are the same storage as logical registers 10–15 of window 0.
- R6: A call alone (`call_i`=1, `ret_i`=0) advances the window index by one modulo 4. A return alone moves it back by one modulo 4. If both are high, the index does not change and neither flag is raised.
- R7: A call made while 4 windows are resident raises `ovf_o` for the one cycle after that edge, and the resident count stays at 4. Otherwise a call adds one to the count.
- R8: A return made while only 1 window is resident raises `unf_o` for the one cycle after that edge, and the resident count stays at 1. Otherwise a return subtracts one from the count.
- R9: A write is translated through the window that is current in the cycle it is presented, even if a call or return changes the window at that same edge.
- R10: Read data is combinational in the read address and the current window. The two read ports return independent registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| rd0_addr | input | 5 | Logical register number for read port 0 |
| rd0_data | output | 32 | Read port 0 data |
| rd1_addr | input | 5 | Logical register number for read port 1 |
| rd1_data | output | 32 | Read port 1 data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register number for the write |
| wr_data | input | 32 | Write data |
| win_o | output | 2 | Current window index |
| ovf_o | output | 1 | One-cycle overflow flag |
| unf_o | output | 1 | One-cycle underflow flag |

## Verification
The bench writes a distinct value to a register in one window and reads it from a neighbouring window. This tells correct sharing apart from an offset error. Globals must survive every move, locals must come back after a call and return, and outgoing registers must show up as the next window's incoming ones. The ring is closed by calling from window 3 into window 0, and that call also causes an overflow. A return straight after reset wraps backwards and causes an underflow. Simultaneous call and return, and a write issued together with a call, separate an update that holds from one that moves the window, and writes that use the old window from writes that use the new one.

// File: rtl/wrf.sv
module wrf #(
  parameter int G  = 10,
  parameter int L  = 10,
  parameter int C  = 6,
  parameter int W  = 4,
  parameter int DW = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       call_i,
  input  logic                       ret_i,
  input  logic [$clog2(G+L+2*C)-1:0] rd0_addr,
  output logic [DW-1:0]              rd0_data,
  input  logic [$clog2(G+L+2*C)-1:0] rd1_addr,
  output logic [DW-1:0]              rd1_data,
  input  logic                       wr_en,
  input  logic [$clog2(G+L+2*C)-1:0] wr_addr,
  input  logic [DW-1:0]              wr_data,
  output logic [$clog2(W)-1:0]       win_o,
  output logic                       ovf_o,
  output logic                       unf_o
);
  localparam int NLOG  = G + L + 2*C;
  localparam int AW    = $clog2(NLOG);
  localparam int STEP  = L + C;
  localparam int RING  = STEP * W;
  localparam int NPHYS = RING + G;
  localparam int PW    = $clog2(NPHYS);
  localparam int WPW   = $clog2(W);
  localparam int RCW   = $clog2(W + 1);

  logic [DW-1:0]  rf [NPHYS];
  logic [WPW-1:0] win_q;
  logic [RCW-1:0] res_q;
  logic           ovf_q, unf_q;

  function automatic logic [PW-1:0] xlate(input logic [AW-1:0] r, input logic [WPW-1:0] w);
    int t;
    if (int'(r) < G) return PW'(int'(r));
    t = (int'(w) * STEP + int'(r) - G) % RING;
    return PW'(G + t);
  endfunction

  assign rd0_data = rf[xlate(rd0_addr, win_q)];
  assign rd1_data = rf[xlate(rd1_addr, win_q)];
  assign win_o    = win_q;
  assign ovf_o    = ovf_q;
  assign unf_o    = unf_q;

  wire do_call = call_i & ~ret_i;
  wire do_ret  = ret_i & ~call_i;

  always_ff @(posedge clk)
    if (wr_en) rf[xlate(wr_addr, win_q)] <= wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
      res_q <= RCW'(1);
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      if (do_call) begin
        win_q <= (win_q == WPW'(W-1)) ? '0 : win_q + 1'b1;
        if (res_q == RCW'(W)) ovf_q <= 1'b1;
        else res_q <= res_q + 1'b1;
      end else if (do_ret) begin
        win_q <= (win_q == '0) ? WPW'(W-1) : win_q - 1'b1;
        if (res_q == RCW'(1)) unf_q <= 1'b1;
        else res_q <= res_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wrf_chk.sv
module wrf_chk #(
  parameter int W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   call_i,
  input logic                   ret_i,
  input logic [$clog2(W)-1:0]   win_o,
  input logic                   ovf_o,
  input logic                   unf_o,
  input logic [$clog2(W+1)-1:0] res
);
  localparam int WPW = $clog2(W);

  AST_CALL_STEP: assert property (@(posedge clk) disable iff (rst)
    (call_i && !ret_i) |=> win_o == WPW'((int'($past(win_o)) + 1) % W)); // R6
  AST_RET_STEP: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !call_i) |=> win_o == WPW'((int'($past(win_o)) + W - 1) % W)); // R6
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (call_i && ret_i) |=> ($stable(win_o) && !ovf_o && !unf_o)); // R6
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> ($past(call_i && !ret_i) && int'($past(res)) == W && int'(res) == W)); // R7
  AST_UNF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    unf_o |-> ($past(ret_i && !call_i) && int'($past(res)) == 1 && int'(res) == 1)); // R8
  AST_RES_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(res) >= 1 && int'(res) <= W)); // R7
endmodule

bind wrf wrf_chk #(.W(W)) chk (
  .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
  .win_o(win_o), .ovf_o(ovf_o), .unf_o(unf_o), .res(res_q)
);

// File: tb/wrf_test.sv
module wrf_test;
  localparam int CLK_P = 10;

  logic        clk = 0, rst = 1, call_i = 0, ret_i = 0, wr_en = 0;
  logic [4:0]  rd0_addr = 0, rd1_addr = 0, wr_addr = 0;
  logic [31:0] wr_data = 0, rd0_data, rd1_data;
  logic [1:0]  win_o;
  logic        ovf_o, unf_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  wrf uut (.clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
    .rd0_addr(rd0_addr), .rd0_data(rd0_data), .rd1_addr(rd1_addr), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .win_o(win_o), .ovf_o(ovf_o), .unf_o(unf_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; call_i = 0; ret_i = 0; wr_en = 0;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic strobe(input logic c, input logic r);
    @(negedge clk); call_i = c; ret_i = r;
    @(negedge clk); call_i = 0; ret_i = 0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd0_addr = 5'(a); #1; d = rd0_data;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 win", 32'(win_o), 0);
    chk("R1 ovf", 32'(ovf_o), 0);
    chk("R1 unf", 32'(unf_o), 0);
  endtask

  task automatic t_globals();
    logic [31:0] v;
    do_reset();
    wr(5, 32'hA5A5_0005);
    strobe(1, 0);
    rd(5, v); chk("R2 global in w1", v, 32'hA5A5_0005);
    wr(9, 32'h0000_0909);
    strobe(0, 1);
    rd(9, v); chk("R2 global back in w0", v, 32'h0000_0909);
  endtask

  task automatic t_locals();
    logic [31:0] v;
    do_reset();
    wr(16, 32'h1111_0016);
    wr(25, 32'h1111_0025);
    strobe(1, 0);
    wr(16, 32'h2222_0016);
    wr(25, 32'h2222_0025);
    strobe(0, 1);
    rd(16, v); chk("R3 local 16", v, 32'h1111_0016);
    rd(25, v); chk("R3 local 25", v, 32'h1111_0025);
  endtask

  task automatic t_overlap();
    logic [31:0] v;
    do_reset();
    for (int k = 0; k < 6; k++) wr(26 + k, 32'hC0DE_0000 + 32'(k));
    strobe(1, 0);
    for (int k = 0; k < 6; k++) begin
      rd(10 + k, v); chk("R4 callee->caller", v, 32'hC0DE_0000 + 32'(k));
    end
    wr(15, 32'hBEEF_0015);
    strobe(0, 1);
    rd(31, v); chk("R4 result back", v, 32'hBEEF_0015);
  endtask

  task automatic t_ring_ovf();
    logic [31:0] v;
    do_reset();
    strobe(1, 0); strobe(1, 0); strobe(1, 0);
    chk("R6 win after 3 calls", 32'(win_o), 3);
    chk("R7 no ovf at 4 resident", 32'(ovf_o), 0);
    wr(28, 32'h7777_0028);
    strobe(1, 0);
    chk("R7 ovf pulse", 32'(ovf_o), 1);
    chk("R6 wrap to 0", 32'(win_o), 0);
    rd(12, v); chk("R5 ring closes", v, 32'h7777_0028);
    @(negedge clk);
    chk("R7 ovf one cycle", 32'(ovf_o), 0);
    strobe(1, 0);
    chk("R7 ovf again at full", 32'(ovf_o), 1);
  endtask

  task automatic t_unf();
    do_reset();
    strobe(0, 1);
    chk("R8 unf pulse", 32'(unf_o), 1);
    chk("R6 wrap back to 3", 32'(win_o), 3);
    strobe(1, 0);
    chk("R8 no ovf after refill", 32'(ovf_o), 0);
    strobe(0, 1);
    chk("R8 no unf with 2 resident", 32'(unf_o), 0);
    strobe(0, 1);
    chk("R8 unf at 1 resident", 32'(unf_o), 1);
  endtask

  task automatic t_both();
    do_reset();
    strobe(1, 0);
    strobe(1, 1);
    chk("R6 both hold win", 32'(win_o), 1);
    chk("R6 both no ovf", 32'(ovf_o), 0);
    chk("R6 both no unf", 32'(unf_o), 0);
  endtask

  task automatic t_write_call();
    logic [31:0] v;
    do_reset();
    @(negedge clk); wr_en = 1; wr_addr = 5'd20; wr_data = 32'h5555_0020; call_i = 1;
    @(negedge clk); wr_en = 0; call_i = 0;
    chk("R9 window moved", 32'(win_o), 1);
    wr(20, 32'h6666_0020);
    strobe(0, 1);
    rd(20, v); chk("R9 write used old window", v, 32'h5555_0020);
  endtask

  task automatic t_dual_read();
    do_reset();
    wr(3, 32'hD0D0_0003);
    wr(30, 32'hD0D0_0030);
    rd0_addr = 5'd3; rd1_addr = 5'd30; #1;
    chk("R10 port0", rd0_data, 32'hD0D0_0003);
    chk("R10 port1", rd1_data, 32'hD0D0_0030);
    rd0_addr = 5'd30; rd1_addr = 5'd3; #1;
    chk("R10 port0 swapped", rd0_data, 32'hD0D0_0030);
    chk("R10 port1 swapped", rd1_data, 32'hD0D0_0003);
  endtask

  initial begin
    t_reset();
    t_globals();
    t_locals();
    t_overlap();
    t_ring_ovf();
    t_unf();
    t_both();
    t_write_call();
    t_dual_read();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule